// File: doc/BRIEF.md
# Pipelined Burst Static Memory Controller Model

This block is a synthesizable model of a synchronous static memory with a registered address stage and a registered read-data stage. A bus master starts an access cycle with one of two active-low strobes. The processor strobe always opens a read cycle. The controller strobe can open either a read or a write cycle, because the write enables are sampled on the edge where it is seen. Once a cycle is open, later edges either write the word at the held address under byte-lane control or read that word again into the output register.

The memory array is a small parameterized register file. Each word has four byte lanes. A chip is selected by three enables, and the master enable gates only starts made through the processor strobe. The read output is presented as a data word plus a separate drive-enable, and is not modelled as a tri-state pin. When a cycle is closed, the drive-enable stays high for one more cycle before it drops (double-cycle deselect).

Top module: `burstSram`

## Requirements
- R1: When `procStrobeN` is sampled low with `chipSel0N` low, `chipSel1` high and `chipSel2N` low, `addr` is registered and a read cycle opens. This holds whatever the levels of `ctrlStrobeN`, `globalWrN`, `byteWrEnN` and `laneWrN`.
- R2: The word at the address registered on edge k appears on `rdData`, with `rdDataOe` high, after edge k+1. It is read again on every later edge of the cycle that carries no write.
- R3: `ctrlStrobeN` sampled low opens a cycle only if `procStrobeN` is sampled high on the same edge. On a start through `ctrlStrobeN`, a write command present on that edge writes `wrData` to the presented `addr` on that edge.
- R4: `chipSel0N` high blocks a start through `procStrobeN`: the registered address and the open cycle are kept. `chipSel0N` does not block a start through `ctrlStrobeN`.
- R5: With `globalWrN` low, all four lanes are written. Otherwise, with `byteWrEnN` low, exactly the lanes whose `laneWrN` bit is low are written. Lane i is `wrData[8i+7:8i]`. `laneWrN` has no effect while `byteWrEnN` is high.
- R6: On an edge that starts a cycle through `procStrobeN`, `globalWrN`, `byteWrEnN` and `laneWrN` are ignored and nothing is written.
- R7: On a later edge of an open cycle where a write is sampled, the write goes to the registered address. `rdDataOe` is low after that edge, whatever the level of `outEnN`.
- R8: `rdDataOe` is high only while `outEnN` is low.
- R9: A cycle closes when a start attempt is sampled with `chipSel1` low or `chipSel2N` high. `rdDataOe` stays high after that edge and goes low after the next edge.
- R10: While no cycle is open, write strobes change no memory word. A cycle opened through `ctrlStrobeN` for a read has `rdDataOe` low after its start edge.
- R11: After reset, `rdDataOe` is low and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| procStrobeN | input | 1 | Processor cycle-start strobe, active low |
| ctrlStrobeN | input | 1 | Controller cycle-start strobe, active low |
| chipSel0N | input | 1 | Master chip enable, active low |
| chipSel1 | input | 1 | Secondary chip enable, active high |
| chipSel2N | input | 1 | Secondary chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| globalWrN | input | 1 | Whole-word write, active low |
| byteWrEnN | input | 1 | Byte-write qualifier, active low |
| laneWrN | input | 4 | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| rdDataOe | output | 1 | Read data drive enable |

## Verification
The bench drives whole-word writes, masked byte writes with lanes chosen so that written and kept lanes alternate, and lane strobes raised without their qualifier. Read-back separates these three cases by value. It starts cycles with both strobes low at once, and with the master enable high on each strobe in turn. These cases show which strobe wins and which strobe the master enable gates. It also places write strobes on processor-start edges and in idle cycles to show that they are dropped. A deselect followed by idle cycles exposes the one-cycle drive tail, and toggling `outEnN` separates the drive gating from the read pipeline.

// File: rtl/burstSramPkg.sv
package burstSramPkg;
  localparam int LANE_CNT = 4;
  localparam int LANE_W   = 8;
  localparam int DATA_W   = LANE_CNT * LANE_W;

  // Per-edge commands from control to the datapath
  typedef struct packed {
    logic                loadAddr;    // capture addr into the address register
    logic                useNewAddr;  // write targets addr rather than the held address
    logic                doRead;      // move the held word into the output register
    logic [LANE_CNT-1:0] wrLanes;     // lanes written on this edge
  } sramStrobes_t;
endpackage

// File: rtl/burstSramCtrl.sv
module burstSramCtrl
  import burstSramPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                chipSel0N,
  input  logic                chipSel1,
  input  logic                chipSel2N,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANE_CNT-1:0] laneWrN,
  output sramStrobes_t        strobes,
  output logic                readValid
);
  logic activeQ;
  logic readValidQ;
  logic secondaryOk;
  logic procTry;
  logic ctrlTry;
  logic startProc;
  logic startCtrl;
  logic deselect;
  logic [LANE_CNT-1:0] sampledLanes;
  logic [LANE_CNT-1:0] laneSel;

  always_comb begin
    secondaryOk = chipSel1 & ~chipSel2N;
    procTry     = ~procStrobeN & ~chipSel0N;   // master enable gates this path only
    ctrlTry     = ~ctrlStrobeN & procStrobeN;  // processor strobe has priority
    startProc   = procTry & secondaryOk;
    startCtrl   = ctrlTry & secondaryOk;
    deselect    = (procTry | ctrlTry) & ~secondaryOk;
  end

  // Lane selection: global write wins, otherwise qualified byte strobes
  for (genvar ln = 0; ln < LANE_CNT; ln++) begin : gLaneSel
    assign sampledLanes[ln] = ~globalWrN | (~byteWrEnN & ~laneWrN[ln]);
  end

  always_comb begin
    if (startProc)      laneSel = '0;
    else if (startCtrl) laneSel = sampledLanes;
    else if (deselect)  laneSel = '0;
    else if (activeQ)   laneSel = sampledLanes;
    else                laneSel = '0;
  end

  always_comb begin
    strobes.loadAddr   = startProc | startCtrl;
    strobes.useNewAddr = startCtrl;
    strobes.wrLanes    = laneSel;
    strobes.doRead     = activeQ & ~(|laneSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ    <= 1'b0;
      readValidQ <= 1'b0;
    end else begin
      if (startProc | startCtrl) activeQ <= 1'b1;
      else if (deselect)         activeQ <= 1'b0;
      readValidQ <= strobes.doRead;
    end
  end

  assign readValid = readValidQ;

  AST_WRITE_BLANKS: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !globalWrN && procStrobeN && ctrlStrobeN) |=> !readValidQ); // R7

  AST_DESEL_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && deselect && globalWrN && byteWrEnN) |=> readValidQ); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!activeQ && procStrobeN && ctrlStrobeN) |=> !readValidQ); // R10
endmodule

// File: rtl/burstSramData.sv
module burstSramData
  import burstSramPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] wrIdx;
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] outQ;

  assign wrIdx   = strobes.useNewAddr ? addr : addrQ;
  assign oldWord = memArr[wrIdx];

  for (genvar ln = 0; ln < LANE_CNT; ln++) begin : gMerge
    assign mergedWord[ln*LANE_W +: LANE_W] = strobes.wrLanes[ln]
      ? wrData[ln*LANE_W +: LANE_W] : oldWord[ln*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
      addrQ <= '0;
      outQ  <= '0;
    end else begin
      if (|strobes.wrLanes) memArr[wrIdx] <= mergedWord;
      if (strobes.loadAddr) addrQ <= addr;
      if (strobes.doRead)   outQ  <= memArr[addrQ];
    end
  end

  assign regAddr = addrQ;
  assign rdData  = outQ;

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doRead |-> !(|strobes.wrLanes)); // R7
endmodule

// File: rtl/burstSram.sv
module burstSram
  import burstSramPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              chipSel0N,
  input  logic              chipSel1,
  input  logic              chipSel2N,
  input  logic              outEnN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [3:0]        laneWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rdDataOe
);
  sramStrobes_t      strobes;
  logic              readValid;
  logic [ADDR_W-1:0] regAddr;

  burstSramCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipSel0N(chipSel0N), .chipSel1(chipSel1), .chipSel2N(chipSel2N),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .strobes(strobes), .readValid(readValid)
  );

  burstSramData #(.ADDR_W(ADDR_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .addr(addr), .wrData(wrData),
    .regAddr(regAddr), .rdData(rdData)
  );

  assign rdDataOe = readValid & ~outEnN;

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipSel0N && chipSel1 && !chipSel2N) |=> (regAddr == $past(addr))); // R1

  AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && chipSel0N && ctrlStrobeN) |=> $stable(regAddr)); // R4
endmodule

// File: tb/burstSram_tb_top.sv
module burstSram_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobeN, ctrlStrobeN, chipSel0N, chipSel1, chipSel2N;
  logic outEnN, globalWrN, byteWrEnN;
  logic [3:0]    laneWrN;
  logic [AW-1:0] addr;
  logic [31:0]   wrData;
  logic [31:0]   rdData;
  logic          rdDataOe;

  typedef struct {
    bit          chkData;
    bit          expOe;
    logic [31:0] expData;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burstSram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .chipSel0N(chipSel0N), .chipSel1(chipSel1), .chipSel2N(chipSel2N),
    .outEnN(outEnN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdDataOe(rdDataOe)
  );

  task automatic setIdle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1;
    chipSel0N = 1'b0; chipSel1 = 1'b1; chipSel2N = 1'b0;
    outEnN = 1'b0; globalWrN = 1'b1; byteWrEnN = 1'b1;
    laneWrN = 4'hF; addr = '0; wrData = '0;
  endtask

  // Driver: queue the expected outputs after the coming edge, then step
  task automatic tick(input bit oe, input logic [31:0] d, input string tag);
    expItem_t it;
    it.chkData = oe; it.expOe = oe; it.expData = d; it.tag = tag;
    scoreQ.push_back(it);
    @(posedge clk);
    @(negedge clk);
    setIdle();
  endtask

  // Monitor: compare outputs shortly after each edge
  always @(posedge clk) begin
    #2;
    if (scoreQ.size() > 0) begin
      expItem_t it;
      it = scoreQ.pop_front();
      nChecks++;
      if (rdDataOe !== it.expOe ||
          (it.chkData && rdData !== it.expData)) begin
        nFails++;
        $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                 it.tag, rdDataOe, rdData, it.expOe, it.expData);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish();
  end

  initial begin
    setIdle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (rdDataOe !== 1'b0) begin
      nFails++;
      $display("FAIL R11: oe=%0b expected oe=0", rdDataOe);
    end
    rstN = 1'b1;

    // R3: controller-strobe start with whole-word write
    ctrlStrobeN = 0; addr = 3; globalWrN = 0; wrData = 32'hA5A5_0001;
    tick(0, 0, "R3 ctrl write start");
    tick(1, 32'hA5A5_0001, "R2 read one edge later");
    // R5: masked byte write, lanes 1 and 3
    ctrlStrobeN = 0; addr = 5; byteWrEnN = 0; laneWrN = 4'b0101; wrData = 32'h1122_3344;
    tick(0, 0, "R5 byte write");
    tick(1, 32'h1100_3300, "R5 lanes merged");
    laneWrN = 4'h0; wrData = 32'hFFFF_FFFF;
    tick(1, 32'h1100_3300, "R5 lanes without qualifier");
    // R7: continuing write to held address blanks output
    globalWrN = 0; wrData = 32'hDEAD_BEEF;
    tick(0, 0, "R7 write blanks output");
    tick(1, 32'hDEAD_BEEF, "R7 write at held address");
    // R6/R1: processor start ignores write enables and controller strobe
    procStrobeN = 0; ctrlStrobeN = 0; addr = 3; globalWrN = 0; byteWrEnN = 0;
    laneWrN = 4'h0; wrData = 32'h0;
    tick(1, 32'hDEAD_BEEF, "R6 proc start no write");
    tick(1, 32'hA5A5_0001, "R1 proc start read");
    // R4: master enable blocks processor start only
    procStrobeN = 0; chipSel0N = 1; addr = 5;
    tick(1, 32'hA5A5_0001, "R4 proc blocked");
    ctrlStrobeN = 0; chipSel0N = 1; addr = 7; globalWrN = 0; wrData = 32'h77;
    tick(0, 0, "R4 ctrl not blocked");
    tick(1, 32'h77, "R4 ctrl write landed");
    // R3: both strobes low, processor wins, no write
    procStrobeN = 0; ctrlStrobeN = 0; addr = 9; globalWrN = 0; wrData = 32'hBAD;
    tick(1, 32'h77, "R3 proc has priority");
    tick(1, 32'h0, "R11 reset word zero");
    // R8: output enable gating
    outEnN = 1;
    tick(0, 0, "R8 oe high");
    tick(1, 32'h0, "R8 oe low");
    // R9: double-cycle deselect
    procStrobeN = 0; addr = 3;
    tick(1, 32'h0, "R9 setup");
    tick(1, 32'hA5A5_0001, "R9 setup read");
    procStrobeN = 0; chipSel1 = 0; addr = 5;
    tick(1, 32'hA5A5_0001, "R9 drive tail");
    tick(0, 0, "R9 released");
    // R10: writes while idle dropped
    globalWrN = 0; wrData = 32'h1234_5678;
    tick(0, 0, "R10 idle write");
    ctrlStrobeN = 0; addr = 3;
    tick(0, 0, "R10 ctrl read start");
    tick(1, 32'hA5A5_0001, "R10 word unchanged");

    @(posedge clk); #4;
    finish();
  end
endmodule